// File: doc/BRIEF.md
# Dual-Channel Serial Interrupt Vector Prioritizer

This block tracks interrupt state for two serial channels, called A (index 0) and B (index 1). Each channel keeps a receive-pending flag, a transmit-pending flag, a receive-in-service mark, a transmit-in-service mark, a character-ready flag, transmit-empty and all-sent flags, and a sticky break flag. The block combines the channel requests into one interrupt line, a six-bit pending summary, and an eight-bit vector that names the most recent source in service. A select input places the source code either in a high or a low bit field of the vector.

The host side drives one-cycle strobes for each channel: a character arrived, a break was detected, the data port was read, the data port was written, clear the transmit interrupt, and release the highest in-service level. While a receive interrupt is in service, a new transmit interrupt waits. It is taken when the receive service ends through a read or a release command. When one source is cleared and the other source on the same channel is still pending, the block brings that source back into service on the following clock.

Top module: `sio_irq_prio`

## Requirements
- R1: After a synchronous reset, the interrupt line is low, the pending summary is 0, all in-service marks and status flags are 0, and the vector holds the idle code for the current select: 0x60 when high, 0x06 when low.
- R2: All outputs are registered and change at the clock edge that samples the stimulus. The interrupt line is the OR of both channel requests. A channel requests when any of these holds: (a) its transmit enable is set and transmit is pending; (b) its two-bit receive mode is 01 or 10 and receive is pending; (c) its break enable is set and its break flag is set.
- R3: Pending summary bits: 0 = break B (flag and enable), 1 = transmit B (pending and enable), 2 = receive B pending, 3 = break A, 4 = transmit A, 5 = receive A. An asserted interrupt line always comes with a non-zero summary.
- R4: A receive event sets receive pending, character-ready and receive-in-service. It loads the receive vector: A gives 0x30 (high) or 0x0C (low), and B gives 0x20 or 0x04.
- R5: A data write sets transmit pending, transmit-empty and all-sent. If receive is not in service, it also sets transmit-in-service and loads the transmit vector: A gives 0x10 or 0x08, and B gives 0x00 under either select. Otherwise the vector and the transmit-in-service mark stay as they were.
- R6: A data read clears receive pending, character-ready and receive-in-service, and loads the idle vector. If transmit is still pending, it is put in service with its vector on the next clock.
- R7: Clear-transmit clears transmit pending and transmit-in-service, and loads the idle vector. If receive is still pending, it is put back in service with its vector on the next clock.
- R8: Release-in-service clears receive-in-service when that mark is set. If transmit is pending at that time, it also sets transmit-in-service and loads the transmit vector in the same cycle. When receive-in-service is already clear, the command clears transmit-in-service and leaves the vector alone.
- R9: The vector only takes the codes listed above. A change of the select re-encodes the held source at the next edge.
- R10: If both channels change the vector in the same cycle, channel A's change is the one taken.
- R11: A break event sets that channel's break flag. The flag stays set until reset and has no effect on the vector.
- R12: Receive modes 00 and 11 do not request an interrupt, but the receive pending bit still appears in the summary.
- R13: When several strobes hit one channel in the same cycle, only the first of this list takes effect: receive, read, write, clear-transmit, release. A break event is applied alongside any of them. A deferred re-evaluation from R6 or R7 is dropped in a cycle that carries a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_stat_hi | input | 1 | Vector select: 1 = high field, 0 = low field |
| cfg_tx_ie | input | NCH | Transmit interrupt enable per channel |
| cfg_rx_mode | input | 2*NCH | Receive interrupt mode, bits [2c+1:2c] for channel c |
| cfg_brk_ie | input | NCH | Break interrupt enable per channel |
| ev_rx | input | NCH | Character received strobe |
| ev_brk | input | NCH | Break detected strobe |
| rd_stb | input | NCH | Data port read strobe |
| wr_stb | input | NCH | Data port write strobe |
| cmd_clr_tx | input | NCH | Clear transmit interrupt command |
| cmd_rst_ius | input | NCH | Release highest in-service command |
| irq_o | output | 1 | Combined interrupt line |
| pend_o | output | 3*NCH | Pending summary |
| vec_o | output | 8 | Modified interrupt vector |
| ius_o | output | 2*NCH | In-service marks: bit 2c receive, bit 2c+1 transmit |
| rx_ready_o | output | NCH | Character ready per channel |
| tx_empty_o | output | NCH | Transmit empty per channel |
| all_sent_o | output | NCH | All sent per channel |
| brk_o | output | NCH | Sticky break flag per channel |

## Verification
The bench builds the block with its default of two channels. This is the only count for which the vector and summary codes are defined, so every A/B interaction is reachable: the cross-channel vector contest, the deferred transmit on each channel, and both fields of the vector. Random strobes include coincident strobes on one channel, which exercises the priority order. Occasional changes to the enables, modes and select bring the gated request terms and the re-encoding of a held source into play.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;

  localparam int unsigned CH_NUM     = 2;
  localparam int unsigned VEC_W      = 8;
  localparam int unsigned SUM_PER_CH = 3;
  localparam int unsigned IUS_PER_CH = 2;

  // Vector change requested by one channel in one cycle
  typedef enum logic [1:0] {
    EV_HOLD = 2'd0,
    EV_IDLE = 2'd1,
    EV_RX   = 2'd2,
    EV_TX   = 2'd3
  } vec_ev_e;

  // Three-bit source code, placed as-is in the high field
  typedef enum logic [2:0] {
    SRC_TX_B = 3'b000,
    SRC_TX_A = 3'b001,
    SRC_RX_B = 3'b010,
    SRC_RX_A = 3'b011,
    SRC_IDLE = 3'b110
  } vsrc_e;

  typedef struct packed {
    logic rx_pend;
    logic tx_pend;
    logic rx_ius;
    logic tx_ius;
    logic rx_rdy;
    logic tx_emp;
    logic sent;
    logic brk;
  } ch_state_t;

  // High select: code at [6:4]; low select: bit-reversed code at [3:1]
  function automatic logic [VEC_W-1:0] vec_encode(vsrc_e src, logic hi);
    logic [2:0] code;
    logic [VEC_W-1:0] v;
    code = src;
    v = '0;
    if (hi) v[6:4] = code;
    else    v[3:1] = {code[0], code[1], code[2]};
    return v;
  endfunction

endpackage

// File: rtl/sio_irq_chan.sv
module sio_irq_chan
  import sio_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tx_ie,
  input  logic [1:0] rx_mode,
  input  logic       brk_ie,
  input  logic       ev_rx,
  input  logic       ev_brk,
  input  logic       rd,
  input  logic       wr,
  input  logic       clr_tx,
  input  logic       rst_ius,
  output ch_state_t  st_q,
  output vec_ev_e    vev_o,
  output logic       req_d,
  output logic [SUM_PER_CH-1:0] sum_q
);

  ch_state_t st_d;
  logic rearm_rx_q, rearm_tx_q;
  logic rearm_rx_d, rearm_tx_d;
  logic rx_mode_on;

  assign rx_mode_on = rx_mode[0] ^ rx_mode[1];

  always_comb begin
    st_d       = st_q;
    vev_o      = EV_HOLD;
    rearm_rx_d = 1'b0;
    rearm_tx_d = 1'b0;
    if (ev_brk) st_d.brk = 1'b1;
    if (ev_rx) begin
      st_d.rx_pend = 1'b1;
      st_d.rx_rdy  = 1'b1;
      st_d.rx_ius  = 1'b1;
      vev_o        = EV_RX;
    end else if (rd) begin
      st_d.rx_pend = 1'b0;
      st_d.rx_rdy  = 1'b0;
      st_d.rx_ius  = 1'b0;
      vev_o        = EV_IDLE;
      rearm_tx_d   = st_q.tx_pend;
    end else if (wr) begin
      st_d.tx_pend = 1'b1;
      st_d.tx_emp  = 1'b1;
      st_d.sent    = 1'b1;
      if (!st_q.rx_ius) begin
        st_d.tx_ius = 1'b1;
        vev_o       = EV_TX;
      end
    end else if (clr_tx) begin
      st_d.tx_pend = 1'b0;
      st_d.tx_ius  = 1'b0;
      vev_o        = EV_IDLE;
      rearm_rx_d   = st_q.rx_pend;
    end else if (rst_ius) begin
      if (st_q.rx_ius) begin
        st_d.rx_ius = 1'b0;
        if (st_q.tx_pend) begin
          st_d.tx_ius = 1'b1;
          vev_o       = EV_TX;
        end
      end else begin
        st_d.tx_ius = 1'b0;
      end
    end else if (rearm_rx_q && st_q.rx_pend) begin
      st_d.rx_ius = 1'b1;
      vev_o       = EV_RX;
    end else if (rearm_tx_q && st_q.tx_pend && !st_q.rx_ius) begin
      st_d.tx_ius = 1'b1;
      vev_o       = EV_TX;
    end
  end

  assign req_d = (tx_ie && st_d.tx_pend) ||
                 (rx_mode_on && st_d.rx_pend) ||
                 (brk_ie && st_d.brk);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= '0;
      rearm_rx_q <= 1'b0;
      rearm_tx_q <= 1'b0;
      sum_q      <= '0;
    end else begin
      st_q       <= st_d;
      rearm_rx_q <= rearm_rx_d;
      rearm_tx_q <= rearm_tx_d;
      sum_q      <= {st_d.rx_pend, tx_ie && st_d.tx_pend, brk_ie && st_d.brk};
    end
  end

endmodule

// File: rtl/sio_irq_vsel.sv
module sio_irq_vsel
  import sio_irq_pkg::*;
#(
  parameter int unsigned NCH = CH_NUM
)(
  input  logic               clk,
  input  logic               rst,
  input  logic               stat_hi,
  input  logic [2*NCH-1:0]   ev_i,
  output logic [VEC_W-1:0]   vec_o
);

  vsrc_e src_q, src_d;

  // Lowest channel index is applied last, so it wins
  always_comb begin
    src_d = src_q;
    for (int c = NCH - 1; c >= 0; c--) begin
      vec_ev_e e;
      e = vec_ev_e'(ev_i[2*c +: 2]);
      case (e)
        EV_IDLE: src_d = SRC_IDLE;
        EV_RX:   src_d = (c == 0) ? SRC_RX_A : SRC_RX_B;
        EV_TX:   src_d = (c == 0) ? SRC_TX_A : SRC_TX_B;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q <= SRC_IDLE;
      vec_o <= vec_encode(SRC_IDLE, stat_hi);
    end else begin
      src_q <= src_d;
      vec_o <= vec_encode(src_d, stat_hi);
    end
  end

endmodule

// File: rtl/sio_irq_prio.sv
module sio_irq_prio
  import sio_irq_pkg::*;
#(
  parameter int unsigned NCH = CH_NUM
)(
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cfg_stat_hi,
  input  logic [NCH-1:0]            cfg_tx_ie,
  input  logic [2*NCH-1:0]          cfg_rx_mode,
  input  logic [NCH-1:0]            cfg_brk_ie,
  input  logic [NCH-1:0]            ev_rx,
  input  logic [NCH-1:0]            ev_brk,
  input  logic [NCH-1:0]            rd_stb,
  input  logic [NCH-1:0]            wr_stb,
  input  logic [NCH-1:0]            cmd_clr_tx,
  input  logic [NCH-1:0]            cmd_rst_ius,
  output logic                      irq_o,
  output logic [SUM_PER_CH*NCH-1:0] pend_o,
  output logic [VEC_W-1:0]          vec_o,
  output logic [IUS_PER_CH*NCH-1:0] ius_o,
  output logic [NCH-1:0]            rx_ready_o,
  output logic [NCH-1:0]            tx_empty_o,
  output logic [NCH-1:0]            all_sent_o,
  output logic [NCH-1:0]            brk_o
);

  localparam int unsigned SUM_W = SUM_PER_CH * NCH;

  logic [NCH-1:0]   req_d;
  logic [2*NCH-1:0] vev;
  logic             irq_q;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int unsigned SBASE = SUM_PER_CH * (NCH - 1 - c);
    ch_state_t st;
    vec_ev_e   ve;

    sio_irq_chan u_chan (
      .clk     (clk),
      .rst     (rst),
      .tx_ie   (cfg_tx_ie[c]),
      .rx_mode (cfg_rx_mode[2*c +: 2]),
      .brk_ie  (cfg_brk_ie[c]),
      .ev_rx   (ev_rx[c]),
      .ev_brk  (ev_brk[c]),
      .rd      (rd_stb[c]),
      .wr      (wr_stb[c]),
      .clr_tx  (cmd_clr_tx[c]),
      .rst_ius (cmd_rst_ius[c]),
      .st_q    (st),
      .vev_o   (ve),
      .req_d   (req_d[c]),
      .sum_q   (pend_o[SBASE +: SUM_PER_CH])
    );

    assign vev[2*c +: 2]                 = ve;
    assign ius_o[IUS_PER_CH*c]           = st.rx_ius;
    assign ius_o[IUS_PER_CH*c + 1]       = st.tx_ius;
    assign rx_ready_o[c]                 = st.rx_rdy;
    assign tx_empty_o[c]                 = st.tx_emp;
    assign all_sent_o[c]                 = st.sent;
    assign brk_o[c]                      = st.brk;
  end

  sio_irq_vsel #(.NCH(NCH)) u_vsel (
    .clk     (clk),
    .rst     (rst),
    .stat_hi (cfg_stat_hi),
    .ev_i    (vev),
    .vec_o   (vec_o)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |req_d;
  end

  assign irq_o = irq_q;

  if (SUM_W == 0) begin : g_bad
    initial $error("sio_irq_prio: empty summary");
  end

endmodule

// File: rtl/sio_irq_prio_chk.sv
module sio_irq_prio_chk
  import sio_irq_pkg::*;
#(
  parameter int unsigned NCH = CH_NUM
)(
  input logic                      clk,
  input logic                      rst,
  input logic                      cfg_stat_hi,
  input logic [NCH-1:0]            ev_rx,
  input logic [NCH-1:0]            rd_stb,
  input logic [NCH-1:0]            wr_stb,
  input logic                      irq_o,
  input logic [SUM_PER_CH*NCH-1:0] pend_o,
  input logic [VEC_W-1:0]          vec_o,
  input logic [IUS_PER_CH*NCH-1:0] ius_o,
  input logic [NCH-1:0]            rx_ready_o,
  input logic [NCH-1:0]            tx_empty_o,
  input logic [NCH-1:0]            all_sent_o,
  input logic [NCH-1:0]            brk_o
);

  // R3: a raised line always has a pending source in the summary
  p_irq_has_pend_r3: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (pend_o != '0));

  // R4: channel A receive always lands the A receive vector
  p_rx_a_vector_r4: assert property (@(posedge clk) disable iff (rst)
    ev_rx[0] |=> (vec_o == ($past(cfg_stat_hi) ? 8'h30 : 8'h0C)));

  // R9: only legal vector codes appear
  p_vec_legal_r9: assert property (@(posedge clk) disable iff (rst)
    (vec_o == 8'h60 || vec_o == 8'h30 || vec_o == 8'h20 || vec_o == 8'h10 ||
     vec_o == 8'h00 || vec_o == 8'h06 || vec_o == 8'h0C || vec_o == 8'h04 ||
     vec_o == 8'h08));

  for (genvar c = 0; c < NCH; c++) begin : g_c
    // R4: receive in service implies a character is ready
    p_ius_needs_rdy_r4: assert property (@(posedge clk) disable iff (rst)
      ius_o[IUS_PER_CH*c] |-> rx_ready_o[c]);

    // R6: a read without a coincident receive empties the character
    p_read_clears_r6: assert property (@(posedge clk) disable iff (rst)
      (rd_stb[c] && !ev_rx[c]) |=> !rx_ready_o[c]);

    // R5: a write taking effect sets both transmit status flags
    p_write_flags_r5: assert property (@(posedge clk) disable iff (rst)
      (wr_stb[c] && !ev_rx[c] && !rd_stb[c]) |=> (tx_empty_o[c] && all_sent_o[c]));

    // R11: break flag is sticky
    p_brk_sticky_r11: assert property (@(posedge clk) disable iff (rst)
      brk_o[c] |=> brk_o[c]);
  end

endmodule

bind sio_irq_prio sio_irq_prio_chk #(.NCH(NCH)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cfg_stat_hi (cfg_stat_hi),
  .ev_rx       (ev_rx),
  .rd_stb      (rd_stb),
  .wr_stb      (wr_stb),
  .irq_o       (irq_o),
  .pend_o      (pend_o),
  .vec_o       (vec_o),
  .ius_o       (ius_o),
  .rx_ready_o  (rx_ready_o),
  .tx_empty_o  (tx_empty_o),
  .all_sent_o  (all_sent_o),
  .brk_o       (brk_o)
);

// File: tb/sio_irq_prio_tb.sv
module sio_irq_prio_tb_top;

  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic       cfg_stat_hi = 1'b1;
  logic [1:0] cfg_tx_ie = '0;
  logic [3:0] cfg_rx_mode = '0;
  logic [1:0] cfg_brk_ie = '0;
  logic [1:0] ev_rx = '0, ev_brk = '0, rd_stb = '0, wr_stb = '0;
  logic [1:0] cmd_clr_tx = '0, cmd_rst_ius = '0;
  logic       irq_o;
  logic [5:0] pend_o;
  logic [7:0] vec_o;
  logic [3:0] ius_o;
  logic [1:0] rx_ready_o, tx_empty_o, all_sent_o, brk_o;

  always #(CLK_P/2) clk = ~clk;

  sio_irq_prio dut_i (
    .clk(clk), .rst(rst), .cfg_stat_hi(cfg_stat_hi), .cfg_tx_ie(cfg_tx_ie),
    .cfg_rx_mode(cfg_rx_mode), .cfg_brk_ie(cfg_brk_ie), .ev_rx(ev_rx),
    .ev_brk(ev_brk), .rd_stb(rd_stb), .wr_stb(wr_stb), .cmd_clr_tx(cmd_clr_tx),
    .cmd_rst_ius(cmd_rst_ius), .irq_o(irq_o), .pend_o(pend_o), .vec_o(vec_o),
    .ius_o(ius_o), .rx_ready_o(rx_ready_o), .tx_empty_o(tx_empty_o),
    .all_sent_o(all_sent_o), .brk_o(brk_o)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // Reference state, built from the requirements
  logic [1:0] m_rxp, m_txp, m_rxs, m_txs, m_rdy, m_emp, m_sent, m_brk, m_arx, m_atx;
  int         m_src;  // 0 idle, 1 rx A, 2 rx B, 3 tx A, 4 tx B
  logic       m_irq;
  logic [5:0] m_pend;
  logic [7:0] m_vec;

  function automatic logic [7:0] exp_vec(int src, logic hi);
    case (src)
      1: return hi ? 8'h30 : 8'h0C;
      2: return hi ? 8'h20 : 8'h04;
      3: return hi ? 8'h10 : 8'h08;
      4: return 8'h00;
      default: return hi ? 8'h60 : 8'h06;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_rxp = '0; m_txp = '0; m_rxs = '0; m_txs = '0; m_rdy = '0;
    m_emp = '0; m_sent = '0; m_brk = '0; m_arx = '0; m_atx = '0;
    m_src = 0; m_irq = 1'b0; m_pend = '0; m_vec = exp_vec(0, cfg_stat_hi);
  endtask

  task automatic model_step();
    int ev [2];   // -1 hold, else new source id
    logic [1:0] nar, nat;
    logic req;
    nar = '0; nat = '0; req = 1'b0;
    for (int c = 0; c < 2; c++) begin
      ev[c] = -1;
      if (ev_brk[c]) m_brk[c] = 1'b1;
      if (ev_rx[c]) begin
        m_rxp[c] = 1; m_rdy[c] = 1; m_rxs[c] = 1; ev[c] = (c == 0) ? 1 : 2;
      end else if (rd_stb[c]) begin
        m_rxp[c] = 0; m_rdy[c] = 0; m_rxs[c] = 0; ev[c] = 0; nat[c] = m_txp[c];
      end else if (wr_stb[c]) begin
        m_txp[c] = 1; m_emp[c] = 1; m_sent[c] = 1;
        if (!m_rxs[c]) begin m_txs[c] = 1; ev[c] = (c == 0) ? 3 : 4; end
      end else if (cmd_clr_tx[c]) begin
        m_txp[c] = 0; m_txs[c] = 0; ev[c] = 0; nar[c] = m_rxp[c];
      end else if (cmd_rst_ius[c]) begin
        if (m_rxs[c]) begin
          m_rxs[c] = 0;
          if (m_txp[c]) begin m_txs[c] = 1; ev[c] = (c == 0) ? 3 : 4; end
        end else m_txs[c] = 0;
      end else if (m_arx[c] && m_rxp[c]) begin
        m_rxs[c] = 1; ev[c] = (c == 0) ? 1 : 2;
      end else if (m_atx[c] && m_txp[c] && !m_rxs[c]) begin
        m_txs[c] = 1; ev[c] = (c == 0) ? 3 : 4;
      end
    end
    m_arx = nar; m_atx = nat;
    if (ev[0] >= 0) m_src = ev[0];
    else if (ev[1] >= 0) m_src = ev[1];
    m_vec = exp_vec(m_src, cfg_stat_hi);
    for (int c = 0; c < 2; c++) begin
      logic modeok;
      modeok = (cfg_rx_mode[2*c +: 2] == 2'b01) || (cfg_rx_mode[2*c +: 2] == 2'b10);
      req = req | (cfg_tx_ie[c] & m_txp[c]) | (modeok & m_rxp[c]) | (cfg_brk_ie[c] & m_brk[c]);
    end
    m_irq = req;
    m_pend = {m_rxp[0], cfg_tx_ie[0] & m_txp[0], cfg_brk_ie[0] & m_brk[0],
              m_rxp[1], cfg_tx_ie[1] & m_txp[1], cfg_brk_ie[1] & m_brk[1]};
  endtask

  task automatic tick();
    @(posedge clk);
    if (rst) model_reset(); else model_step();
    @(negedge clk);
    ev_rx = '0; ev_brk = '0; rd_stb = '0; wr_stb = '0; cmd_clr_tx = '0; cmd_rst_ius = '0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    tick(); tick();
    rst = 1'b0;
  endtask

  task automatic chk_all(input string tag);
    chk({tag, " R2 irq"}, irq_o, m_irq);
    chk({tag, " R3 pend"}, pend_o, m_pend);
    chk({tag, " R9 vec"}, vec_o, m_vec);
    chk({tag, " R8 ius"}, ius_o, {m_txs[1], m_rxs[1], m_txs[0], m_rxs[0]});
    chk({tag, " R4 rdy"}, rx_ready_o, m_rdy);
    chk({tag, " R5 flags"}, {tx_empty_o, all_sent_o}, {m_emp, m_sent});
    chk({tag, " R11 brk"}, brk_o, m_brk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240607));
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk("R1 irq", irq_o, 0); chk("R1 pend", pend_o, 0);
    chk("R1 vec", vec_o, 8'h60); chk("R1 ius", ius_o, 0);
    chk("R1 flags", {rx_ready_o, tx_empty_o, all_sent_o, brk_o}, 0);

    cfg_tx_ie = 2'b11; cfg_rx_mode = 4'b0101; cfg_brk_ie = 2'b11; cfg_stat_hi = 1;
    ev_rx[0] = 1; tick();
    chk("R4 vec rxA hi", vec_o, 8'h30); chk("R2 irq", irq_o, 1);
    chk("R3 pend rxA", pend_o, 8'h20); chk("R4 ius", ius_o, 4'b0001);
    chk("R4 rdy", rx_ready_o, 2'b01);

    wr_stb[0] = 1; tick();
    chk("R5 deferred vec", vec_o, 8'h30); chk("R5 deferred ius", ius_o, 4'b0001);
    chk("R5 pend", pend_o, 8'h30); chk("R5 flags", {tx_empty_o[0], all_sent_o[0]}, 2'b11);

    cmd_rst_ius[0] = 1; tick();
    chk("R8 tx taken vec", vec_o, 8'h10); chk("R8 ius", ius_o, 4'b0010);
    cmd_rst_ius[0] = 1; tick();
    chk("R8 tx release ius", ius_o, 4'b0000); chk("R8 vec held", vec_o, 8'h10);

    cmd_clr_tx[0] = 1; tick();
    chk("R7 idle vec", vec_o, 8'h60); chk("R7 pend", pend_o, 8'h20);
    tick();
    chk("R7 rx reinstated vec", vec_o, 8'h30); chk("R7 ius", ius_o, 4'b0001);

    wr_stb[0] = 1; tick();
    chk("R5 deferred again", vec_o, 8'h30);
    rd_stb[0] = 1; tick();
    chk("R6 idle vec", vec_o, 8'h60); chk("R6 rdy", rx_ready_o, 2'b00);
    chk("R6 pend", pend_o, 8'h10);
    tick();
    chk("R6 tx reinstated vec", vec_o, 8'h10); chk("R6 ius", ius_o, 4'b0010);

    cfg_stat_hi = 0; tick();
    chk("R9 reencode lo", vec_o, 8'h08);

    ev_rx[1] = 1; tick();
    chk("R4 vec rxB lo", vec_o, 8'h04); chk("R3 pend B", pend_o, 8'h14);
    wr_stb[1] = 1; tick();
    chk("R5 B deferred", vec_o, 8'h04); chk("R3 pend txB", pend_o, 8'h16);
    rd_stb[1] = 1; tick();
    chk("R6 B idle lo", vec_o, 8'h06);
    tick();
    chk("R5 txB vec", vec_o, 8'h00);

    ev_rx = 2'b11; tick();
    chk("R10 A wins", vec_o, 8'h0C); chk("R10 pend", pend_o, 8'h36);

    do_reset();
    cfg_stat_hi = 1; cfg_tx_ie = 0; cfg_brk_ie = 0; cfg_rx_mode = 4'b0011;
    ev_rx[0] = 1; tick();
    chk("R12 mode11 irq", irq_o, 0); chk("R12 pend", pend_o, 8'h20);
    cfg_rx_mode = 4'b0000; tick();
    chk("R12 mode00 irq", irq_o, 0);
    cfg_rx_mode = 4'b0010; tick();
    chk("R2 mode10 irq", irq_o, 1);
    rd_stb[0] = 1; tick();
    chk("R2 cleared irq", irq_o, 0);
    ev_brk[1] = 1; tick();
    chk("R11 brk flag", brk_o, 2'b10); chk("R11 irq gated", irq_o, 0);
    chk("R11 vec unchanged", vec_o, 8'h60);
    cfg_brk_ie = 2'b10; tick();
    chk("R11 irq", irq_o, 1); chk("R3 ext B bit", pend_o, 8'h01);
    cfg_brk_ie = 2'b11; tick();
    chk("R3 ext A absent", pend_o, 8'h01);

    ev_rx[0] = 1; rd_stb[0] = 1; tick();
    chk("R13 rx over read", rx_ready_o[0], 1); chk("R13 vec", vec_o, 8'h30);

    // random phase against the reference
    do_reset();
    model_reset();
    chk_all("R1 rand-reset");
    for (int i = 0; i < 4000; i++) begin
      if (($urandom % 40) == 0) begin
        cfg_stat_hi = $urandom; cfg_tx_ie = $urandom; cfg_rx_mode = $urandom; cfg_brk_ie = $urandom;
      end
      for (int c = 0; c < 2; c++) begin
        int r;
        r = $urandom % 16;
        ev_rx[c]       = (r == 0) || (r == 10);
        rd_stb[c]      = (r == 1) || (r == 2) || (r == 10);
        wr_stb[c]      = (r == 3) || (r == 4) || (r == 11);
        cmd_clr_tx[c]  = (r == 5) || (r == 11);
        cmd_rst_ius[c] = (r == 6) || (r == 7);
        ev_brk[c]      = (($urandom % 64) == 0);
      end
      tick();
      chk_all("R13 rand");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule